// File: doc/BRIEF.md
# Superslice Dispatch Slot Allocator

This block takes a group of up to eight decoded internal operations each cycle and decides which of them dispatch and where each one goes. There are four execution slices, 0 to 3, organised as two superslices: slices 0 and 1 form superslice 0, and slices 2 and 3 form superslice 1. A separate branch slice takes branch operations.

Each operation carries a dispatch-rule tag and the number of its primary sources. Every slice has one dedicated dispatch port. Each superslice also has one shared port that can steer an operation to either of its two slices. The branch slice has two ports. The caller supplies the free entry count of each slice's issue queue. The block returns an accept mask, a slot code for each operation, and the number of queue entries it consumed in each slice, so that the caller can update its counts. Operations dispatch strictly in program order: the first operation that cannot be placed stops every younger operation, and those operations are presented again in a later cycle.

The decision is combinational. The result is registered, so the outputs for a group appear in the cycle after the group was presented. The block has no state machine. Its only state is the output register, which holds either the reset value or the last decision.

Top module: `dispatch_slot_alloc`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the accept mask, all slot codes and all consumption counts are zero.
- R2: The accept mask always covers a contiguous run of operations starting at operation 0, and it includes only valid operations. Once an operation fails to place, no younger operation is accepted.
- R3: No more than six dispatch slots are used per cycle. Every accepted operation uses one slot, except a paired operation, which uses two.
- R4: A normal operation (rule code 0, also used for reserved codes 6 and 7) first tries the dedicated ports of slices 0, 1, 2 and 3, in that order. If none is available, it tries the shared port of superslice 0 and then the shared port of superslice 1. A shared port sends the operation to the even slice if that slice has room, and otherwise to the odd slice. Slot codes 0 to 3 name the slice.
- R5: Only an operation with at most two primary sources may use a shared port.
- R6: An even-only operation (rule code 2) needs both dedicated ports of a superslice and takes both of them. It lands on the even slice only and consumes one entry there.
- R7: A vector operation (rule code 1) takes the even dedicated port of a superslice and lands on both of its slices, consuming one entry in each. Its slot code is the even slice.
- R8: A paired operation (rule code 3) carries both halves. It needs both dedicated ports of one superslice, lands on both slices with one entry each, and counts as two slots toward the limit in R3. Its slot code is the even slice.
- R9: A tuple-restricted operation (rule code 4) goes only to a superslice that has nothing else assigned in that cycle, and it lands on the even slice. After it is placed, nothing else is assigned to that superslice in that cycle.
- R10: A branch operation (rule code 5) gets slot code 4 and uses no execution queue. At most two branches are accepted per cycle.
- R11: No slice receives more than two operations per cycle. The entries consumed in a slice never exceed its free count, and the count reported for each slice is exactly the number of entries placed there.
- R12: The decision for the inputs presented before a rising clock edge appears on the outputs after that edge, and the outputs do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 8 | Operation present, bit i for operation i (0 is oldest) |
| op_rule_i | input | 24 | 3-bit rule code per operation: 0 normal, 1 vector, 2 even-only, 3 paired, 4 tuple-restricted, 5 branch |
| op_nsrc_i | input | 16 | 2-bit primary source count per operation |
| q_free_i | input | 16 | 4-bit free entry count per slice, slice 0 in the low bits |
| accept_o | output | 8 | Operations dispatched this cycle |
| slot_o | output | 24 | 3-bit slot code per operation: 0 to 3 slice, 4 branch, 0 when not accepted |
| q_used_o | output | 16 | 4-bit entries consumed per slice |

## Verification
The assertions check on every cycle that the accept mask is a prefix of the valid operations, that the slot limit and the branch limit hold, that no slice's consumption exceeds the free count that was registered with it, and that reset clears the outputs. The ordering of port choices, the superslice rules for even-only, vector, paired and tuple-restricted operations, the source-count limit on the shared ports, and the exact consumption counts can be shown only by comparing the outputs against the bench's behavioural model, using directed groups and a long run of random groups.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

    typedef enum logic [2:0] {
        RULE_PLAIN = 3'd0,
        RULE_VEC   = 3'd1,
        RULE_EVEN  = 3'd2,
        RULE_PAIR  = 3'd3,
        RULE_TUPLE = 3'd4,
        RULE_BR    = 3'd5
    } rule_e;

    localparam int unsigned N_SLICE   = 4;
    localparam int unsigned RULE_W    = 3;
    localparam int unsigned SLOT_W    = 3;
    localparam int unsigned NSRC_W    = 2;
    localparam int unsigned BR_PORTS  = 2;
    localparam int unsigned SLICE_CAP = 2;
    localparam logic [2:0]  SLOT_BR   = 3'd4;

endpackage

// File: rtl/dsa_alloc.sv
module dsa_alloc
    import dsa_pkg::*;
#(
    parameter int unsigned NUM_OPS  = 8,
    parameter int unsigned MAX_DISP = 6,
    parameter int unsigned QW       = 4
) (
    input  logic [NUM_OPS-1:0]        valid_i,
    input  logic [NUM_OPS*RULE_W-1:0] rule_i,
    input  logic [NUM_OPS*NSRC_W-1:0] nsrc_i,
    input  logic [N_SLICE*QW-1:0]     qfree_i,
    output logic [NUM_OPS-1:0]        acc_o,
    output logic [NUM_OPS*SLOT_W-1:0] slot_o,
    output logic [N_SLICE*QW-1:0]     used_o
);

    localparam int unsigned N_SS = N_SLICE / 2;

    function automatic logic room(input logic [1:0] l, input logic [QW:0] u, input logic [QW:0] f);
        return (l < 2'(SLICE_CAP)) && (u < f);
    endfunction

    logic [N_SLICE-1:0] ded;
    logic [N_SS-1:0]    shr, lock, touch;
    logic [1:0]         land [N_SLICE];
    logic [QW:0]        used [N_SLICE];
    logic [QW:0]        free [N_SLICE];
    int unsigned        tot, nbr, wt, e;
    logic               stop, ok, dual, isbr;
    logic [2:0]         tgt;
    rule_e              rule;

    always_comb begin
        ded = '0; shr = '0; lock = '0; touch = '0;
        tot = 0; nbr = 0; stop = 1'b0;
        ok = 1'b0; dual = 1'b0; isbr = 1'b0; tgt = '0; wt = 1; e = 0;
        rule = RULE_PLAIN;
        acc_o = '0; slot_o = '0; used_o = '0;
        for (int s = 0; s < N_SLICE; s++) begin
            land[s] = '0;
            used[s] = '0;
            free[s] = {1'b0, qfree_i[s*QW +: QW]};
        end
        for (int i = 0; i < NUM_OPS; i++) begin
            rule = rule_e'(rule_i[i*RULE_W +: RULE_W]);
            ok = 1'b0; dual = 1'b0; isbr = 1'b0; tgt = '0;
            wt = (rule == RULE_PAIR) ? 2 : 1;
            if (valid_i[i] && !stop && (tot + wt <= MAX_DISP)) begin
                case (rule)
                    RULE_BR: begin
                        if (nbr < BR_PORTS) begin
                            ok = 1'b1; isbr = 1'b1; tgt = SLOT_BR; nbr = nbr + 1;
                        end
                    end
                    RULE_EVEN: begin
                        for (int ss = 0; ss < N_SS; ss++) begin
                            e = 2 * ss;
                            if (!ok && !lock[ss] && !ded[e] && !ded[e+1]
                                && room(land[e], used[e], free[e])) begin
                                ok = 1'b1; tgt = 3'(e); ded[e] = 1'b1; ded[e+1] = 1'b1;
                            end
                        end
                    end
                    RULE_VEC: begin
                        for (int ss = 0; ss < N_SS; ss++) begin
                            e = 2 * ss;
                            if (!ok && !lock[ss] && !ded[e]
                                && room(land[e], used[e], free[e])
                                && room(land[e+1], used[e+1], free[e+1])) begin
                                ok = 1'b1; dual = 1'b1; tgt = 3'(e); ded[e] = 1'b1;
                            end
                        end
                    end
                    RULE_PAIR: begin
                        for (int ss = 0; ss < N_SS; ss++) begin
                            e = 2 * ss;
                            if (!ok && !lock[ss] && !ded[e] && !ded[e+1]
                                && room(land[e], used[e], free[e])
                                && room(land[e+1], used[e+1], free[e+1])) begin
                                ok = 1'b1; dual = 1'b1; tgt = 3'(e);
                                ded[e] = 1'b1; ded[e+1] = 1'b1;
                            end
                        end
                    end
                    RULE_TUPLE: begin
                        for (int ss = 0; ss < N_SS; ss++) begin
                            e = 2 * ss;
                            if (!ok && !touch[ss] && room(land[e], used[e], free[e])) begin
                                ok = 1'b1; tgt = 3'(e); ded[e] = 1'b1; lock[ss] = 1'b1;
                            end
                        end
                    end
                    default: begin
                        for (int s = 0; s < N_SLICE; s++) begin
                            if (!ok && !ded[s] && !lock[s/2] && room(land[s], used[s], free[s])) begin
                                ok = 1'b1; tgt = 3'(s); ded[s] = 1'b1;
                            end
                        end
                        if (!ok && (nsrc_i[i*NSRC_W +: NSRC_W] <= 2'd2)) begin
                            for (int ss = 0; ss < N_SS; ss++) begin
                                e = 2 * ss;
                                if (!ok && !shr[ss] && !lock[ss]) begin
                                    if (room(land[e], used[e], free[e])) begin
                                        ok = 1'b1; tgt = 3'(e); shr[ss] = 1'b1;
                                    end else if (room(land[e+1], used[e+1], free[e+1])) begin
                                        ok = 1'b1; tgt = 3'(e + 1); shr[ss] = 1'b1;
                                    end
                                end
                            end
                        end
                    end
                endcase
            end
            if (ok) begin
                tot = tot + wt;
                acc_o[i] = 1'b1;
                slot_o[i*SLOT_W +: SLOT_W] = tgt;
                if (!isbr) begin
                    touch[tgt[1]] = 1'b1;
                    land[tgt[1:0]] = land[tgt[1:0]] + 2'd1;
                    used[tgt[1:0]] = used[tgt[1:0]] + 1'b1;
                    if (dual) begin
                        land[tgt[1:0] + 2'd1] = land[tgt[1:0] + 2'd1] + 2'd1;
                        used[tgt[1:0] + 2'd1] = used[tgt[1:0] + 2'd1] + 1'b1;
                    end
                end
            end else begin
                stop = 1'b1;
            end
        end
        for (int s = 0; s < N_SLICE; s++) begin
            used_o[s*QW +: QW] = used[s][QW-1:0];
        end
    end

endmodule

// File: rtl/dsa_pipe.sv
module dsa_pipe
    import dsa_pkg::*;
#(
    parameter int unsigned NUM_OPS = 8,
    parameter int unsigned QW      = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_OPS-1:0]        acc_d,
    input  logic [NUM_OPS*SLOT_W-1:0] slot_d,
    input  logic [N_SLICE*QW-1:0]     used_d,
    output logic [NUM_OPS-1:0]        acc_q,
    output logic [NUM_OPS*SLOT_W-1:0] slot_q,
    output logic [N_SLICE*QW-1:0]     used_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            slot_q <= '0;
            used_q <= '0;
        end else begin
            acc_q  <= acc_d;
            slot_q <= slot_d;
            used_q <= used_d;
        end
    end

endmodule

// File: rtl/dispatch_slot_alloc.sv
module dispatch_slot_alloc
    import dsa_pkg::*;
#(
    parameter int unsigned NUM_OPS  = 8,
    parameter int unsigned MAX_DISP = 6,
    parameter int unsigned QW       = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_OPS-1:0]        op_valid_i,
    input  logic [NUM_OPS*RULE_W-1:0] op_rule_i,
    input  logic [NUM_OPS*NSRC_W-1:0] op_nsrc_i,
    input  logic [N_SLICE*QW-1:0]     q_free_i,
    output logic [NUM_OPS-1:0]        accept_o,
    output logic [NUM_OPS*SLOT_W-1:0] slot_o,
    output logic [N_SLICE*QW-1:0]     q_used_o
);

    logic [NUM_OPS-1:0]        acc_c;
    logic [NUM_OPS*SLOT_W-1:0] slot_c;
    logic [N_SLICE*QW-1:0]     used_c;

    dsa_alloc #(.NUM_OPS(NUM_OPS), .MAX_DISP(MAX_DISP), .QW(QW)) alloc_i (
        .valid_i (op_valid_i),
        .rule_i  (op_rule_i),
        .nsrc_i  (op_nsrc_i),
        .qfree_i (q_free_i),
        .acc_o   (acc_c),
        .slot_o  (slot_c),
        .used_o  (used_c)
    );

    dsa_pipe #(.NUM_OPS(NUM_OPS), .QW(QW)) pipe_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc_d  (acc_c),
        .slot_d (slot_c),
        .used_d (used_c),
        .acc_q  (accept_o),
        .slot_q (slot_o),
        .used_q (q_used_o)
    );

    // Branch slots among the registered accepted operations
    int unsigned br_seen;
    always_comb begin
        br_seen = 0;
        for (int i = 0; i < NUM_OPS; i++) begin
            if (accept_o[i] && (slot_o[i*SLOT_W +: SLOT_W] == SLOT_BR)) br_seen = br_seen + 1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (accept_o == '0) && (q_used_o == '0) && (slot_o == '0));

    p_prefix_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((accept_o & (accept_o + 1'b1)) == '0));

    p_valid_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((accept_o & ~$past(op_valid_i)) == '0));

    p_slot_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(accept_o) <= MAX_DISP);

    p_branch_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        br_seen <= BR_PORTS);

    for (genvar s = 0; s < N_SLICE; s++) begin : g_q_chk
        p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (q_used_o[s*QW +: QW] <= $past(q_free_i[s*QW +: QW])));
        p_slice_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
            q_used_o[s*QW +: QW] <= QW'(2 * SLICE_CAP));
    end

endmodule

// File: tb/dispatch_slot_alloc_tb_top.sv
`timescale 1ns/100ps
module dispatch_slot_alloc_tb_top;

    localparam int NOPS = 8;
    localparam int QW   = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NOPS-1:0] valid;
    logic [NOPS*3-1:0] rule;
    logic [NOPS*2-1:0] nsrc;
    logic [4*QW-1:0] qfree;
    logic [NOPS-1:0] acc;
    logic [NOPS*3-1:0] slot;
    logic [4*QW-1:0] used;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // model expectation
    int exp_acc;
    int exp_slot [NOPS];
    int exp_used [4];

    always #2.5 clk = ~clk;

    dispatch_slot_alloc dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid_i(valid), .op_rule_i(rule),
        .op_nsrc_i(nsrc), .q_free_i(qfree), .accept_o(acc), .slot_o(slot), .q_used_o(used)
    );

    task automatic chk(input string tag, input bit good, input int act, input int expv);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int qf(input int s);
        return int'(qfree[s*QW +: QW]);
    endfunction

    // Behavioural reference: walks the group in order with counters per slice.
    task automatic model();
        int portbusy [4];
        int shbusy [2];
        int closed [2];
        int hit [2];
        int cnt [4];
        int take [4];
        int budget = 6;
        int br = 0;
        bit halted = 0;
        for (int s = 0; s < 4; s++) begin portbusy[s] = 0; cnt[s] = 0; take[s] = 0; end
        for (int k = 0; k < 2; k++) begin shbusy[k] = 0; closed[k] = 0; hit[k] = 0; end
        exp_acc = 0;
        for (int i = 0; i < NOPS; i++) begin
            int r = int'(rule[i*3 +: 3]);
            int ns = int'(nsrc[i*2 +: 2]);
            int cost = (r == 3) ? 2 : 1;
            int where = -1;
            bit both = 0;
            exp_slot[i] = 0;
            if (halted || !valid[i] || cost > budget) begin
                halted = 1;
                continue;
            end
            if (r == 5) begin
                if (br < 2) begin br++; where = 4; end
            end else if (r == 2 || r == 3) begin
                for (int k = 0; k < 2 && where < 0; k++) begin
                    int ev = 2 * k;
                    bit fit = !closed[k] && !portbusy[ev] && !portbusy[ev+1] &&
                              cnt[ev] < 2 && take[ev] < qf(ev);
                    if (r == 3) fit = fit && cnt[ev+1] < 2 && take[ev+1] < qf(ev+1);
                    if (fit) begin
                        where = ev; portbusy[ev] = 1; portbusy[ev+1] = 1; both = (r == 3);
                    end
                end
            end else if (r == 1) begin
                for (int k = 0; k < 2 && where < 0; k++) begin
                    int ev = 2 * k;
                    if (!closed[k] && !portbusy[ev] && cnt[ev] < 2 && take[ev] < qf(ev) &&
                        cnt[ev+1] < 2 && take[ev+1] < qf(ev+1)) begin
                        where = ev; portbusy[ev] = 1; both = 1;
                    end
                end
            end else if (r == 4) begin
                for (int k = 0; k < 2 && where < 0; k++) begin
                    if (!hit[k] && cnt[2*k] < 2 && take[2*k] < qf(2*k)) begin
                        where = 2 * k; portbusy[2*k] = 1; closed[k] = 1;
                    end
                end
            end else begin
                for (int s = 0; s < 4 && where < 0; s++)
                    if (!portbusy[s] && !closed[s/2] && cnt[s] < 2 && take[s] < qf(s)) begin
                        where = s; portbusy[s] = 1;
                    end
                if (where < 0 && ns <= 2)
                    for (int k = 0; k < 2 && where < 0; k++)
                        if (!shbusy[k] && !closed[k]) begin
                            for (int h = 0; h < 2 && where < 0; h++)
                                if (cnt[2*k+h] < 2 && take[2*k+h] < qf(2*k+h)) where = 2 * k + h;
                            if (where >= 0) shbusy[k] = 1;
                        end
            end
            if (where < 0) begin
                halted = 1;
            end else begin
                budget -= cost;
                exp_acc |= (1 << i);
                exp_slot[i] = where;
                if (where < 4) begin
                    hit[where/2] = 1;
                    cnt[where]++; take[where]++;
                    if (both) begin cnt[where+1]++; take[where+1]++; end
                end
            end
        end
        for (int s = 0; s < 4; s++) exp_used[s] = take[s];
    endtask

    task automatic compare(input string tag);
        chk({tag, " accept"}, acc == exp_acc[NOPS-1:0], int'(acc), exp_acc);
        for (int i = 0; i < NOPS; i++)
            chk({tag, " slot"}, int'(slot[i*3 +: 3]) == exp_slot[i], int'(slot[i*3 +: 3]), exp_slot[i]);
        for (int s = 0; s < 4; s++)
            chk({tag, " used"}, int'(used[s*QW +: QW]) == exp_used[s], int'(used[s*QW +: QW]), exp_used[s]);
    endtask

    task automatic clear_ops();
        valid = '0; rule = '0; nsrc = '0;
        qfree = {4{4'd11}};
    endtask

    task automatic put(input int i, input int r, input int ns);
        valid[i] = 1'b1;
        rule[i*3 +: 3] = 3'(r);
        nsrc[i*2 +: 2] = 2'(ns);
    endtask

    // present current inputs, step one clock, compare at the following negedge
    task automatic step(input string tag);
        model();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_ops();
        repeat (3) @(negedge clk);
        chk("R1 reset accept", acc == '0, int'(acc), 0);
        chk("R1 reset used", used == '0, int'(used), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset accept", acc == '0, int'(acc), 0);

        // R3 R4: eight normal two-source ops
        clear_ops();
        for (int i = 0; i < 8; i++) put(i, 0, 2);
        #1;
        chk("R12 no change before edge", acc == '0, int'(acc), 0);
        step("R4");
        chk("R3 six accepted", acc == 8'h3F, int'(acc), 'h3F);
        chk("R4 shared to slice0", slot[4*3 +: 3] == 3'd0, int'(slot[4*3 +: 3]), 0);
        chk("R4 shared to slice2", slot[5*3 +: 3] == 3'd2, int'(slot[5*3 +: 3]), 2);
        chk("R11 used", used == 16'h1212, int'(used), 'h1212);

        // R5: three-source ops cannot use shared ports
        clear_ops();
        for (int i = 0; i < 6; i++) put(i, 0, 3);
        step("R5");
        chk("R5 only dedicated", acc == 8'h0F, int'(acc), 'h0F);

        // R6 and R2: even-only ops then a normal op behind a failure
        clear_ops();
        put(0, 2, 1); put(1, 2, 1); put(2, 2, 1); put(3, 0, 1);
        step("R6");
        chk("R6 two placed, R2 younger held", acc == 8'h03, int'(acc), 'h03);
        chk("R6 used even only", used == 16'h0101, int'(used), 'h0101);

        // R7 vector
        clear_ops();
        put(0, 1, 2); put(1, 0, 3);
        step("R7");
        chk("R7 accept", acc == 8'h03, int'(acc), 'h03);
        chk("R7 normal to slice1", slot[1*3 +: 3] == 3'd1, int'(slot[1*3 +: 3]), 1);
        chk("R7 used both slices", used == 16'h0021, int'(used), 'h0021);

        // R8 paired counts two toward the limit
        clear_ops();
        put(0, 3, 1); put(1, 3, 1); put(2, 5, 0); put(3, 5, 0); put(4, 0, 2);
        step("R8");
        chk("R8 limit", acc == 8'h0F, int'(acc), 'h0F);
        chk("R8 used", used == 16'h1111, int'(used), 'h1111);

        // R3: branch blocked by the slot limit
        clear_ops();
        for (int i = 0; i < 5; i++) put(i, 0, 2);
        put(5, 5, 0); put(6, 5, 0);
        step("R3");
        chk("R3 seventh held", acc == 8'h3F, int'(acc), 'h3F);

        // R9 tuple
        clear_ops();
        put(0, 0, 2); put(1, 4, 2); put(2, 0, 2); put(3, 0, 2); put(4, 0, 2);
        step("R9");
        chk("R9 accept", acc == 8'h0F, int'(acc), 'h0F);
        chk("R9 tuple slot2", slot[1*3 +: 3] == 3'd2, int'(slot[1*3 +: 3]), 2);
        chk("R9 used", used == 16'h0112, int'(used), 'h0112);

        // R10 branches
        clear_ops();
        put(0, 5, 0); put(1, 5, 0); put(2, 5, 0);
        step("R10");
        chk("R10 two branches", acc == 8'h03, int'(acc), 'h03);
        chk("R10 slot code", slot[2:0] == 3'd4, int'(slot[2:0]), 4);
        chk("R10 no queue use", used == '0, int'(used), 0);

        // R11 queue limits
        clear_ops();
        qfree = {4'd11, 4'd11, 4'd1, 4'd0};
        for (int i = 0; i < 4; i++) put(i, 0, 2);
        step("R11");
        chk("R11 accept", acc == 8'h0F, int'(acc), 'h0F);
        chk("R11 used", used == 16'h1210, int'(used), 'h1210);

        // random groups against the model (R2)
        for (int n = 0; n < 3000; n++) begin
            clear_ops();
            for (int i = 0; i < NOPS; i++) begin
                valid[i] = ($urandom_range(9) != 0);
                rule[i*3 +: 3] = 3'($urandom_range(7));
                nsrc[i*2 +: 2] = 2'($urandom_range(3));
            end
            for (int s = 0; s < 4; s++) qfree[s*QW +: QW] = 4'($urandom_range(11));
            step("R2 random");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule